// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the configuration and interrupt-mask state of a host-to-I/O bridge as a bank of 28 word-wide registers, reachable through a simple word-only bus slave at byte offsets 0x00 to 0x6C. Most registers are plain storage that software writes and reads back. The interrupt-enable mask cannot be written directly: software changes it through a set alias, which ORs bits in, and a clear alias, which removes bits. The mask and the interrupt status word are read-only at their own offsets.

A self-reset bit (bit 2) in the general configuration register lets software reset the system. A write that moves this bit from 0 to 1 makes the block emit a one-cycle system reset request. Writing the bit while it is already 1, or leaving it at 0, does nothing. Every register takes a fixed default when the block's own reset is asserted.

Two small state machines do the sequencing. The read-port machine has the states RD_IDLE and RD_RESP. A read request moves it to RD_RESP, and it stays there while reads arrive back to back. It returns to RD_IDLE on the first cycle with no read. The reset-pulse machine has the states RP_IDLE and RP_FIRE. A qualifying 0-to-1 write moves it to RP_FIRE. It always leaves RP_FIRE for RP_IDLE after one cycle.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset the registers read back these defaults: 0x00=0x00000C40, 0x04=0x00001384 (bits 2, 7, 8, 9 and 12 set), 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other mapped offset reads 0.
- R2: Every mapped offset except 0x38 and 0x3C stores all 32 bits of a write, and a later read returns that value.
- R3: A write to the set alias at 0x30 stores the value there. In the same cycle it ORs the value into the enable mask at 0x38.
- R4: A write to the clear alias at 0x34 stores the value there. In the same cycle it clears the written 1 bits in the enable mask at 0x38.
- R5: Direct writes to 0x38 and 0x3C have no effect. The mask changes only through 0x30 and 0x34, and 0x3C keeps reading 0.
- R6: A write to 0x04 that changes bit 2 from 0 to 1 drives sw_reset_req high for exactly one cycle, starting in the cycle after the write edge.
- R7: A write to 0x04 that leaves bit 2 at 1, or writes it as 0, does not raise sw_reset_req.
- R8: Offsets 0x70 and above are unmapped. Reads of them return 0, and writes to them change no register.
- R9: An access whose byte address has bits [1:0] not equal to 0 is ignored. A write of this kind changes nothing, and a read of this kind returns 0.
- R10: bus_rvalid is high in the cycle after a read request, with bus_rdata holding the value the register had at that request. A write request does not raise bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads all defaults |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| sw_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check four things on every cycle. The enable mask holds its bits set after a set-alias write and holds them clear after a clear-alias write. The mask stays stable when neither alias is written. The reset request never lasts more than one cycle, and it follows every 0-to-1 self-reset write and no other write to that register. A read is answered in the next cycle, and an unmapped or misaligned read answers 0. Only the bench's scenarios can show the full default table, the read-back of arbitrary data at plain offsets, and that ignored writes to read-only, unmapped or misaligned addresses leave every register unchanged.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 28;
    localparam int IDX_W    = $clog2(NUM_REGS);

    // Word indices whose behaviour differs from plain storage
    localparam int GEN_IDX  = 1;   // general configuration (0x04)
    localparam int SET_IDX  = 12;  // enable set alias (0x30)
    localparam int CLR_IDX  = 13;  // enable clear alias (0x34)
    localparam int MASK_IDX = 14;  // enable mask, read-only (0x38)
    localparam int STAT_IDX = 15;  // interrupt status, read-only (0x3C)
    localparam int SRST_BIT = 2;   // self-reset bit inside GEN_IDX

    typedef enum logic [2:0] {
        K_PLAIN,
        K_SET_ALIAS,
        K_CLR_ALIAS,
        K_MASK,
        K_RDONLY
    } reg_kind_e;

    function automatic reg_kind_e kind_of(input int idx);
        if (idx == SET_IDX)  return K_SET_ALIAS;
        if (idx == CLR_IDX)  return K_CLR_ALIAS;
        if (idx == MASK_IDX) return K_MASK;
        if (idx == STAT_IDX) return K_RDONLY;
        return K_PLAIN;
    endfunction

    function automatic logic [DATA_W-1:0] default_of(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode
    import ctrlreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = addr[ADDR_W-1:2];
        idx  = word[IDX_W-1:0];
        hit  = (addr[1:0] == 2'b00) && (int'(word) < NUM_REGS);
    end
endmodule

// File: rtl/ctrlreg_bank.sv
module ctrlreg_bank
    import ctrlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              srst_rise
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic              wr_hit;

    assign wr_hit = wr_en && hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam reg_kind_e KIND = kind_of(i);
        if (KIND == K_MASK) begin : g_mask
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[i] <= default_of(i);
                end else if (wr_hit && int'(idx) == SET_IDX) begin
                    regs_q[i] <= regs_q[i] | wdata;
                end else if (wr_hit && int'(idx) == CLR_IDX) begin
                    regs_q[i] <= regs_q[i] & ~wdata;
                end
            end
        end else if (KIND == K_RDONLY) begin : g_ro
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[i] <= default_of(i);
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[i] <= default_of(i);
                end else if (wr_hit && int'(idx) == i) begin
                    regs_q[i] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit && int'(idx) == i) rd_data = regs_q[i];
        end
    end

    assign srst_rise = wr_hit && int'(idx) == GEN_IDX
                       && !regs_q[GEN_IDX][SRST_BIT] && wdata[SRST_BIT];

    // R3: bits written through the set alias are present in the mask next cycle
    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && int'(idx) == SET_IDX)
        |=> ((regs_q[MASK_IDX] & $past(wdata)) == $past(wdata)));

    // R4: bits written through the clear alias are absent from the mask next cycle
    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && int'(idx) == CLR_IDX)
        |=> ((regs_q[MASK_IDX] & $past(wdata)) == '0));

    // R5: mask only moves on an alias write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && (int'(idx) == SET_IDX || int'(idx) == CLR_IDX))
        |=> $stable(regs_q[MASK_IDX]));
endmodule

// File: rtl/ctrlreg_rstpulse.sv
module ctrlreg_rstpulse (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    typedef enum logic {RP_IDLE, RP_FIRE} rp_state_e;

    rp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (trigger) state_d = RP_FIRE;
            RP_FIRE: state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            RP_IDLE: pulse = 1'b0;
            RP_FIRE: pulse = 1'b1;
        endcase
    end

    // R6: the request never lasts longer than one cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/ctrlreg_rdport.sv
module ctrlreg_rdport
    import ctrlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    typedef enum logic {RD_IDLE, RD_RESP} rd_state_e;

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_req)  state_d = RD_RESP;
            RD_RESP: if (!rd_req) state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) data_q <= rd_data;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        unique case (state_q)
            RD_IDLE: rvalid = 1'b0;
            RD_RESP: rvalid = 1'b1;
        endcase
        rdata = data_q;
    end

    // R10: every read request is answered in the following cycle
    p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
    import ctrlreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              sw_reset_req
);
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_data;
    logic              srst_rise;
    logic              wr_en;
    logic              rd_req;

    assign wr_en  = bus_req && bus_we;
    assign rd_req = bus_req && !bus_we;

    ctrlreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    ctrlreg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .idx       (idx),
        .hit       (hit),
        .wdata     (bus_wdata),
        .rd_data   (rd_data),
        .srst_rise (srst_rise)
    );

    ctrlreg_rstpulse u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (srst_rise),
        .pulse   (sw_reset_req)
    );

    ctrlreg_rdport u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_data (rd_data),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata)
    );

    // R6: a 0-to-1 self-reset write is followed by the request
    p_rise_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst_rise |=> sw_reset_req);

    // R7: a self-reset write that is not a rise never fires the request
    p_no_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && int'(idx) == GEN_IDX && !srst_rise) |=> !sw_reset_req);

    // R8/R9: an unmapped or misaligned read answers zero
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !hit) |=> (bus_rdata == '0));

    // R10: writes never produce a read response
    p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> !bus_rvalid);
endmodule

// File: tb/sim_bridge_ctl_regs.sv
module sim_bridge_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        sw_reset_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bridge_ctl_regs u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rvalid   (bus_rvalid),
        .bus_rdata    (bus_rdata),
        .sw_reset_req (sw_reset_req)
    );

    function automatic logic [31:0] expect_default(input int off);
        case (off)
            8'h00: return 32'h0000_0C40;
            8'h04: return 32'h0000_1384;
            8'h08: return 32'h2BFF_8010;
            8'h0C: return 32'h255E_0091;
            8'h10: return 32'h0000_6140;
            8'h1C: return 32'h0000_01FF;
            8'h20: return 32'h0000_01FF;
            8'h68: return 32'h0000_0008;
            8'h6C: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // write; returns the reset request seen in the cycle after the edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic pulse);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        pulse = sw_reset_req;
        check("R10 no rvalid on write", {31'b0, bus_rvalid}, 32'h0);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        check("R10 rvalid after read", {31'b0, bus_rvalid}, 32'h1);
        d = bus_rdata;
    endtask

    task automatic t_defaults();
        logic [31:0] v;
        check("R1 rvalid idle at reset", {31'b0, bus_rvalid}, 32'h0);
        check("R1 no reset request at reset", {31'b0, sw_reset_req}, 32'h0);
        for (int off = 0; off < 8'h70; off += 4) begin
            bus_read(off[7:0], v);
            check("R1 default", v, expect_default(off));
        end
    endtask

    task automatic t_plain_rw();
        logic [31:0] v;
        logic p;
        bus_write(8'h08, 32'hDEAD_BEEF, p);
        bus_write(8'h40, 32'h1234_5678, p);
        bus_write(8'h6C, 32'hFFFF_FFFF, p);
        bus_write(8'h00, 32'h0000_0000, p);
        bus_read(8'h08, v); check("R2 readback 0x08", v, 32'hDEAD_BEEF);
        bus_read(8'h40, v); check("R2 readback 0x40", v, 32'h1234_5678);
        bus_read(8'h6C, v); check("R2 readback 0x6C", v, 32'hFFFF_FFFF);
        bus_read(8'h00, v); check("R2 readback 0x00", v, 32'h0);
    endtask

    task automatic t_mask_alias();
        logic [31:0] v;
        logic p;
        bus_write(8'h30, 32'h0000_00F0, p);
        bus_read(8'h38, v); check("R3 mask after set", v, 32'h0000_00F0);
        bus_read(8'h30, v); check("R3 set alias stored", v, 32'h0000_00F0);
        bus_write(8'h30, 32'h0000_0F00, p);
        bus_read(8'h38, v); check("R3 mask ORed", v, 32'h0000_0FF0);
        bus_write(8'h34, 32'h0000_00F0, p);
        bus_read(8'h38, v); check("R4 mask after clear", v, 32'h0000_0F00);
        bus_read(8'h34, v); check("R4 clear alias stored", v, 32'h0000_00F0);
        bus_write(8'h38, 32'hFFFF_FFFF, p);
        bus_read(8'h38, v); check("R5 mask ignores direct write", v, 32'h0000_0F00);
        bus_write(8'h3C, 32'hA5A5_A5A5, p);
        bus_read(8'h3C, v); check("R5 status ignores write", v, 32'h0);
    endtask

    task automatic t_self_reset();
        logic [31:0] v;
        logic p;
        bus_write(8'h04, 32'h0000_1384, p);
        check("R7 no pulse when bit already 1", {31'b0, p}, 32'h0);
        bus_write(8'h04, 32'h0000_1380, p);
        check("R7 no pulse on clearing", {31'b0, p}, 32'h0);
        bus_read(8'h04, v); check("R2 gencfg readback", v, 32'h0000_1380);
        bus_write(8'h04, 32'h0000_0004, p);
        check("R6 pulse after 0->1", {31'b0, p}, 32'h1);
        @(negedge clk);
        check("R6 pulse lasts one cycle", {31'b0, sw_reset_req}, 32'h0);
        bus_write(8'h04, 32'h0000_0004, p);
        check("R7 no pulse on repeat", {31'b0, p}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic p;
        bus_write(8'h70, 32'h5555_5555, p);
        bus_read(8'h70, v); check("R8 unmapped read 0x70", v, 32'h0);
        bus_read(8'hFC, v); check("R8 unmapped read 0xFC", v, 32'h0);
        bus_read(8'h6C, v); check("R8 neighbour unchanged", v, 32'hFFFF_FFFF);
        bus_read(8'h2C, v); check("R8 low alias unchanged", v, 32'h0);
    endtask

    task automatic t_misaligned();
        logic [31:0] v;
        logic p;
        bus_write(8'h41, 32'h0BAD_0BAD, p);
        bus_write(8'h32, 32'hFFFF_FFFF, p);
        bus_read(8'h40, v); check("R9 misaligned write ignored", v, 32'h1234_5678);
        bus_read(8'h38, v); check("R9 misaligned alias ignored", v, 32'h0000_0F00);
        bus_read(8'h42, v); check("R9 misaligned read zero", v, 32'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_defaults();
        t_plain_rw();
        t_mask_alias();
        t_self_reset();
        t_unmapped();
        t_misaligned();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule